// File: doc/BRIEF.md
# Second-Pulse Gated Serial Transmitter

This block is an 8N1 serial transmitter whose message start is tied to a once-per-second timing pulse. Software or an upstream engine writes bytes into a small holding buffer whenever it likes, using a ready/valid handshake. The bytes are not sent on arrival. A rising edge on the pulse input starts a delay counter in system-clock cycles. When the delay expires, whatever is buffered is released and sent with no idle gap between frames. The falling edge of the first start bit then lands at a fixed offset from the pulse, and a receiver can use it as a time marker.

The transmitter runs from an internal tick at 16 times the baud rate. The release is tested on every one of those ticks, not once per bit. The start edge therefore trails the delay expiry by at most one tick period, which is 1/16 of a bit. A typical setting is a delay of half a second, and the delay and the tick divisor are both inputs counted in system clocks. Bytes that arrive after the buffer has drained wait for the next pulse plus the delay. A pulse that arrives while a frame is on the line restarts the delay count and leaves the frame untouched.

Top module: `pps_gated_uart_tx`

## Requirements
- R1: After reset, `tx` is 1, `busy` is 0 and `wr_ready` is 1.
- R2: Buffered bytes are not transmitted, and `tx` stays 1, until the delay that follows a rising edge of `pps` has expired.
- R3: The 16x tick fires once every `tick_div` system clocks (every clock when `tick_div` is 0 or 1). Each serial bit lasts 16 ticks, and `tx` changes only on a tick.
- R4: Let E0 be the clock edge that samples a rising edge of `pps`, with buffered data waiting. The first start bit begins on the first 16x tick edge after edge E0+`delay_cycles`. That is between `delay_cycles`+1 and `delay_cycles`+`tick_div` clocks after E0 (a delay of 0 acts as 1).
- R5: Each frame is a start bit of 0, then eight data bits least significant first, then one stop bit of 1. The line idles at 1.
- R6: Once released, all bytes buffered at that time are sent back to back. Each start bit follows the previous one by exactly 160 ticks.
- R7: A delay expiry with an empty buffer releases nothing. A byte written after the buffer has drained, including one written in the same cycle as the last byte is taken, waits for the next `pps` edge plus the delay.
- R8: A `pps` edge restarts the delay count from zero, whether the delay is still counting or a frame is being sent. A frame on the line is never cut short or altered.
- R9: The buffer holds 16 bytes. `wr_ready` is 0 while it is full, and a write attempted then is dropped.
- R10: `busy` is 1 exactly while a frame, from start bit through stop bit, is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps | input | 1 | Timing pulse, rising edge starts the delay (synchronous to clk) |
| delay_cycles | input | DLY_W | Delay from pulse edge to release, in clocks |
| tick_div | input | DIV_W | Clocks per 16x baud tick |
| wr_data | input | 8 | Byte to buffer |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Buffer can accept a byte |
| tx | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is on the line |

## Verification
The hardest cases to reach are the timing races around the release. These are a pulse arriving again before the first delay has expired, a pulse arriving in the middle of a frame, and an expiry that finds the buffer empty while a byte shows up shortly afterwards. The stimulus reaches them by placing pulses at chosen offsets from measured start edges and by writing bytes before, between and after pulses. A behavioural model with a byte queue predicts `tx`, `busy` and `wr_ready` on every clock. A line decoder in the bench rebuilds the bytes and measures the latency from the pulse to the start edge and the spacing between frames.

// File: rtl/pps_gated_uart_tx.sv
module pps_gated_uart_tx #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  parameter int DLY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps,
  input  logic [DLY_W-1:0] delay_cycles,
  input  logic [DIV_W-1:0] tick_div,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             tx,
  output logic             busy
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic             pps_q;
  logic             pps_rise;
  logic [DIV_W-1:0] tick_cnt;
  logic             tick;
  logic             armed;
  logic [DLY_W-1:0] dly_cnt;
  logic             expire;
  logic             released;
  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push, pop;
  logic             shifting;
  logic [3:0]       sub;
  logic [3:0]       bitn;
  logic [9:0]       shreg;
  logic             frame_end;

  assign pps_rise  = pps & ~pps_q;
  assign tick      = ({1'b0, tick_cnt} + (DIV_W+1)'(1)) >= {1'b0, tick_div};
  assign expire    = armed & ~pps_rise & (({1'b0, dly_cnt} + (DLY_W+1)'(1)) >= {1'b0, delay_cycles});
  assign wr_ready  = count != CW'(DEPTH);
  assign push      = wr_valid & wr_ready;
  assign frame_end = shifting & tick & (sub == 4'd15) & (bitn == 4'd9);
  assign pop       = tick & released & (count != '0) & (~shifting | frame_end);
  assign tx        = shifting ? shreg[0] : 1'b1;
  assign busy      = shifting;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pps_q    <= 1'b0;
      tick_cnt <= '0;
    end else begin
      pps_q    <= pps;
      tick_cnt <= tick ? '0 : tick_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      dly_cnt <= '0;
    end else if (pps_rise) begin
      armed   <= 1'b1;
      dly_cnt <= '0;
    end else if (armed) begin
      if (expire) armed <= 1'b0;
      else        dly_cnt <= dly_cnt + DLY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                released <= 1'b0;
    else if (expire && (count != CW'(pop)))    released <= 1'b1;
    else if (pop && (count == CW'(1)))         released <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shifting <= 1'b0;
      sub      <= '0;
      bitn     <= '0;
      shreg    <= '1;
    end else if (pop) begin
      shifting <= 1'b1;
      sub      <= '0;
      bitn     <= '0;
      shreg    <= {1'b1, mem[rd_ptr], 1'b0};
    end else if (shifting && tick) begin
      if (sub == 4'd15) begin
        sub <= '0;
        if (bitn == 4'd9) begin
          shifting <= 1'b0;
        end else begin
          bitn  <= bitn + 4'd1;
          shreg <= {1'b1, shreg[9:1]};
        end
      end else begin
        sub <= sub + 4'd1;
      end
    end
  end
endmodule

// File: rtl/pps_gated_uart_tx_chk.sv
module pps_gated_uart_tx_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx,
  input logic          busy,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          tick,
  input logic          released,
  input logic [CW-1:0] count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && !wr_ready) |=> (count <= $past(count))); // R9
  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(released)); // R2
  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(tick)); // R4
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !tx); // R5
  AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && !$past(tick)) |-> $stable(tx)); // R3
endmodule

bind pps_gated_uart_tx pps_gated_uart_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx(tx), .busy(busy), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .tick(tick), .released(released), .count(count)
);

// File: tb/pps_gated_uart_tx_tb.sv
module pps_gated_uart_tx_tb;
  localparam int DIV   = 3;
  localparam int DLY   = 200;
  localparam int BITC  = 16 * DIV;
  localparam int FRAME = 10 * BITC;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        pps = 0;
  logic [7:0]  wr_data = 0;
  logic        wr_valid = 0;
  logic        wr_ready, tx, busy;
  logic [31:0] delay_cycles = DLY;
  logic [15:0] tick_div = DIV;

  always #4 clk = ~clk;

  pps_gated_uart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .pps(pps), .delay_cycles(delay_cycles),
    .tick_div(tick_div), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .tx(tx), .busy(busy)
  );

  int nchk = 0, nerr = 0, cyc = 0, pps_cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] mq[$];
  int m_tcnt, m_dcnt, m_sub, m_bit;
  bit m_arm, m_rel, m_sh, m_pps;
  logic [7:0] m_byte;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_tcnt = 0; m_dcnt = 0; m_sub = 0; m_bit = 0;
      m_arm = 0; m_rel = 0; m_sh = 0; m_pps = 0; m_byte = 0;
    end else begin
      bit t, pr, push, fend, pop, ex;
      int cnt;
      t    = (m_tcnt + 1 >= DIV);
      pr   = pps && !m_pps;
      cnt  = mq.size();
      push = wr_valid && cnt < 16;
      fend = m_sh && t && m_sub == 15 && m_bit == 9;
      pop  = t && m_rel && cnt > 0 && (!m_sh || fend);
      ex   = m_arm && !pr && (m_dcnt + 1 >= DLY);
      if (ex && cnt > int'(pop)) m_rel = 1;
      else if (pop && cnt == 1) m_rel = 0;
      if (pop) begin
        m_byte = mq.pop_front(); m_sh = 1; m_sub = 0; m_bit = 0;
      end else if (m_sh && t) begin
        if (m_sub == 15) begin
          m_sub = 0;
          if (m_bit == 9) m_sh = 0; else m_bit++;
        end else m_sub++;
      end
      if (push) mq.push_back(wr_data);
      if (pr) begin m_arm = 1; m_dcnt = 0; end
      else if (m_arm) begin if (ex) m_arm = 0; else m_dcnt++; end
      m_tcnt = t ? 0 : m_tcnt + 1;
      m_pps = pps;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit etx;
      etx = !m_sh ? 1'b1 : (m_bit == 0) ? 1'b0 : (m_bit == 9) ? 1'b1 : m_byte[m_bit-1];
      chk(tx == etx, "R5 tx vs model", tx, etx);
      chk(busy == m_sh, "R10 busy vs model", busy, m_sh);
      chk(wr_ready == (mq.size() < 16), "R9 wr_ready vs model", wr_ready, mq.size() < 16);
    end
  end

  logic [7:0] rx_q[$];
  int start_q[$];
  bit d_act = 0;
  int d_st;
  logic [7:0] d_b;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!d_act) begin
        if (tx === 1'b0) begin d_act = 1; d_st = cyc; d_b = 0; end
      end else begin
        int off;
        off = cyc - d_st;
        if (off == BITC - 1) chk(tx == 0, "R3 start bit length", tx, 0);
        if (off >= BITC + BITC/2 && off <= BITC + BITC/2 + 7*BITC && (off - BITC - BITC/2) % BITC == 0)
          d_b[(off - BITC - BITC/2) / BITC] = tx;
        if (off == BITC/2 + 9*BITC) begin
          chk(tx == 1, "R5 stop bit", tx, 1);
          rx_q.push_back(d_b);
          start_q.push_back(d_st);
          d_act = 0;
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_valid = 1; wr_data = b;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pulse_pps();
    @(negedge clk); pps = 1;
    @(negedge clk); pps_cyc = cyc; pps = 0;
  endtask

  task automatic clear_rx();
    rx_q.delete(); start_q.delete();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int p1, lat;
    logic [7:0] exp16[$];
    wait_n(5);
    rst_n = 1;
    @(negedge clk);
    chk(tx == 1, "R1 tx after reset", tx, 1);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(wr_ready == 1, "R1 wr_ready after reset", wr_ready, 1);

    write_byte(8'h01); write_byte(8'hA5); write_byte(8'h3C);
    wait_n(400);
    chk(start_q.size() == 0, "R2 held before pps", start_q.size(), 0);
    pulse_pps();
    wait_n(DLY + 3*FRAME + 100);
    chk(rx_q.size() == 3, "R6 byte count", rx_q.size(), 3);
    if (rx_q.size() == 3) begin
      lat = start_q[0] - pps_cyc;
      chk(lat >= DLY + 1 && lat <= DLY + DIV, "R4 start latency", lat, DLY + 1);
      chk(rx_q[0] == 8'h01, "R5 byte0", rx_q[0], 8'h01);
      chk(rx_q[1] == 8'hA5, "R5 byte1", rx_q[1], 8'hA5);
      chk(rx_q[2] == 8'h3C, "R5 byte2", rx_q[2], 8'h3C);
      chk(start_q[1] - start_q[0] == FRAME, "R6 gap 0-1", start_q[1] - start_q[0], FRAME);
      chk(start_q[2] - start_q[1] == FRAME, "R6 gap 1-2", start_q[2] - start_q[1], FRAME);
    end
    chk(busy == 0, "R10 idle after frames", busy, 0);
    clear_rx();

    pulse_pps();
    wait_n(DLY + 100);
    write_byte(8'h5A);
    wait_n(600);
    chk(start_q.size() == 0, "R7 late byte waits", start_q.size(), 0);
    pulse_pps();
    wait_n(DLY + FRAME + 100);
    chk(rx_q.size() == 1, "R7 sent after next pps", rx_q.size(), 1);
    if (rx_q.size() == 1) begin
      chk(rx_q[0] == 8'h5A, "R7 byte", rx_q[0], 8'h5A);
      lat = start_q[0] - pps_cyc;
      chk(lat >= DLY + 1 && lat <= DLY + DIV, "R7 latency", lat, DLY + 1);
    end
    clear_rx();

    write_byte(8'h11); write_byte(8'h22);
    pulse_pps();
    p1 = pps_cyc;
    wait_n(100);
    pulse_pps();
    wait_n(DLY + DIV + 200);
    chk(busy == 1, "R10 busy mid frame", busy, 1);
    pulse_pps();
    wait_n(2*FRAME + 100);
    chk(rx_q.size() == 2, "R8 frames survive pps", rx_q.size(), 2);
    if (rx_q.size() == 2) begin
      lat = start_q[0] - (p1 + 102);
      chk(lat >= DLY + 1 && lat <= DLY + DIV, "R8 restarted delay", lat, DLY + 1);
      chk(start_q[0] - p1 > DLY + DIV, "R8 first expiry cancelled", start_q[0] - p1, DLY + DIV + 1);
      chk(rx_q[0] == 8'h11 && rx_q[1] == 8'h22, "R8 bytes intact", rx_q[1], 8'h22);
      chk(start_q[1] - start_q[0] == FRAME, "R8 spacing", start_q[1] - start_q[0], FRAME);
    end
    clear_rx();

    for (int i = 0; i < 16; i++) begin
      write_byte(8'(i*7 + 3));
      exp16.push_back(8'(i*7 + 3));
    end
    @(negedge clk);
    chk(wr_ready == 0, "R9 full", wr_ready, 0);
    wr_valid = 1; wr_data = 8'hFF;
    @(negedge clk);
    chk(wr_ready == 0, "R9 full during write", wr_ready, 0);
    wr_valid = 0;
    pulse_pps();
    wait_n(DLY + 16*FRAME + 300);
    chk(rx_q.size() == 16, "R9 16 bytes sent", rx_q.size(), 16);
    for (int i = 0; i < 16 && i < rx_q.size(); i++)
      chk(rx_q[i] == exp16[i], "R9 byte order", rx_q[i], exp16[i]);
    chk(wr_ready == 1, "R9 ready after drain", wr_ready, 1);

    summary();
    $finish;
  end
endmodule